// File: doc/BRIEF.md
# Block-Protocol Character and Block Waiting Timer

This block supervises the timing of a half-duplex, block-oriented smart card link. It runs entirely on the card clock. An internal divider turns a programmable clocks-per-etu value into an elementary time unit pulse, and three timers are measured against character leading edges reported by the surrounding receiver and transmitter. The block does not decode characters or make protocol decisions. It only reports when a timing limit has been crossed, or when the link may be turned around.

The character timer catches a received block whose length is wrong. It fires when the card leaves too long a gap between two characters of its block, and that limit is (2^CWI + 11) etu, with CWI a 4-bit configuration index. The block timer catches an unresponsive card. It is armed at the leading edge of the last character the interface sends and runs until the card's first reply character. Its limit is mult x 2^BWI x UNIT card clocks plus 11 etu. UNIT is a parameter and defaults to 960 x 372 clocks. BWI is a 4-bit index. mult is a waiting-time extension that the protocol layer hands in, and it applies to a single reply only. A guard output stays low for 22 etu after each received character's leading edge, so the interface never answers too early.

Typical defaults are CWI = 13, BWI = 4 and 372 clocks per etu. Both indices are configuration inputs. A clocks-per-etu value of zero behaves as one.

Top module: `t1_wait_timer`

## Requirements
- R1: The etu period is cfg_etu_div card clocks, and a value of 0 acts as 1. Every rx_char_start restarts the etu phase, so etu-based limits count whole etus from the edge that sampled the strobe.
- R2: With no further strobe, char_timeout rises exactly ((1 << cfg_cwi) + 11) x etu clocks after the edge that sampled rx_char_start. It then stays high.
- R3: rx_char_start clears char_timeout from the next cycle on and starts a fresh character wait.
- R4: tx_allowed is low from the cycle after an rx_char_start until exactly 22 x etu clocks after that edge, and it goes high at that edge.
- R5: After reset, char_timeout and block_timeout are 0 and tx_allowed is 1.
- R6: tx_char_start together with tx_char_last arms the block wait and clears block_timeout from the next cycle on. block_timeout rises exactly m x (UNIT << cfg_bwi) + 11 x etu clocks after the arming edge. cfg_bwi is sampled at that edge, and m = 1 unless R8 applies.
- R7: An rx_char_start while the block wait is armed stops it, and block_timeout stays low.
- R8: A wtx_valid pulse stores wtx_mult as m for the next arming only. Later armings use m = 1 again. A stored value of 0 acts as 1.
- R9: tx_char_start without tx_char_last does not arm the block wait.
- R10: tx_char_start ends any running character wait, so char_timeout stays low until the next rx_char_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_etu_div | input | DIV_W | Card clocks per etu (0 acts as 1) |
| cfg_cwi | input | IDX_W | Character wait exponent index |
| cfg_bwi | input | IDX_W | Block wait exponent index |
| rx_char_start | input | 1 | Leading edge of a received character |
| tx_char_start | input | 1 | Leading edge of a transmitted character |
| tx_char_last | input | 1 | Qualifies tx_char_start as the last character of the block |
| wtx_valid | input | 1 | Accepted waiting-time extension strobe |
| wtx_mult | input | MULT_W | Extension multiplier for the next block wait |
| char_timeout | output | 1 | Inter-character gap exceeded (wrong block length) |
| block_timeout | output | 1 | No reply within the block wait (card unresponsive) |
| tx_allowed | output | 1 | Guard time since the last received character has elapsed |

## Verification
On every cycle, the embedded assertions check the local cause-and-effect rules. A strobe clears or closes the output it governs on the next cycle. A timeout can only rise from an armed timer. The guard only opens on an etu pulse. The etu pulse never repeats back to back unless the divisor is one. The stored multiplier is never zero. The exact expiry cycles are shown only by the bench scenarios, because they depend on the arithmetic of the divisor, the indices and the multiplier. The bench sweeps those values and checks each output one cycle before and at its expected edge. It also covers disarming by the opposite-direction strobe, the one-shot nature of the extension, and the zero divisor and zero multiplier cases.

// File: rtl/t1wt_pkg.sv
package t1wt_pkg;
  localparam int EXTRA_ETU = 11;  // character allowance added to waits
  localparam int GUARD_ETU = 22;  // turnaround guard
endpackage

// File: rtl/t1wt_etu_gen.sv
module t1wt_etu_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = !restart && (cnt_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || div <= DIV_W'(1))); // R1
endmodule

// File: rtl/t1wt_char_guard.sv
module t1wt_char_guard
  import t1wt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx_start,
  input  logic             tx_start,
  input  logic [IDX_W-1:0] cwi,
  output logic             char_timeout,
  output logic             tx_allowed
);
  localparam int CW_W = (1 << IDX_W) + 1;
  localparam int GW   = $clog2(GUARD_ETU + 1);

  logic [CW_W-1:0] cw_lim;
  logic [CW_W-1:0] cw_cnt_q;
  logic            cw_armed_q;
  logic [GW-1:0]   g_cnt_q;

  assign cw_lim = (CW_W'(1) << cwi) + CW_W'(EXTRA_ETU);

  // character waiting timer
  always_ff @(posedge clk) begin
    if (rst) begin
      cw_armed_q   <= 1'b0;
      cw_cnt_q     <= '0;
      char_timeout <= 1'b0;
    end else if (rx_start) begin
      cw_armed_q   <= 1'b1;
      cw_cnt_q     <= '0;
      char_timeout <= 1'b0;
    end else if (tx_start) begin
      cw_armed_q   <= 1'b0;
      char_timeout <= 1'b0;
    end else if (cw_armed_q && tick) begin
      if (cw_cnt_q >= cw_lim - CW_W'(1)) begin
        char_timeout <= 1'b1;
        cw_armed_q   <= 1'b0;
      end else begin
        cw_cnt_q <= cw_cnt_q + CW_W'(1);
      end
    end
  end

  // turnaround guard
  always_ff @(posedge clk) begin
    if (rst) begin
      g_cnt_q    <= '0;
      tx_allowed <= 1'b1;
    end else if (rx_start) begin
      g_cnt_q    <= '0;
      tx_allowed <= 1'b0;
    end else if (!tx_allowed && tick) begin
      if (g_cnt_q >= GW'(GUARD_ETU - 1)) tx_allowed <= 1'b1;
      else                               g_cnt_q    <= g_cnt_q + GW'(1);
    end
  end

  AST_CT_CLEARED_BY_RX: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> !char_timeout); // R3
  AST_CT_CLEARED_BY_TX: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !rx_start) |=> !char_timeout); // R10
  AST_CT_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(char_timeout) |-> $past(cw_armed_q)); // R2
  AST_GUARD_CLOSES: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> !tx_allowed); // R4
  AST_GUARD_OPENS_ON_ETU: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_allowed) |-> $past(tick)); // R4
endmodule

// File: rtl/t1wt_block_wait.sv
module t1wt_block_wait
  import t1wt_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DIV_W  = 16,
  parameter int MULT_W = 8,
  parameter int UNIT   = 357120,
  parameter int BLK_W  = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div,
  input  logic [IDX_W-1:0]  bwi,
  input  logic              arm,
  input  logic              rx_start,
  input  logic              wtx_valid,
  input  logic [MULT_W-1:0] wtx_mult,
  output logic              block_timeout
);
  logic [DIV_W-1:0]  div_eff;
  logic [MULT_W-1:0] mult_q;
  logic [BLK_W-1:0]  lim_next;
  logic [BLK_W-1:0]  lim_q;
  logic [BLK_W-1:0]  cnt_q;
  logic              armed_q;

  assign div_eff  = (div == '0) ? DIV_W'(1) : div;
  assign lim_next = (BLK_W'(UNIT) << bwi) * BLK_W'(mult_q)
                  + BLK_W'(EXTRA_ETU) * BLK_W'(div_eff);

  // one-shot extension multiplier
  always_ff @(posedge clk) begin
    if (rst)            mult_q <= MULT_W'(1);
    else if (wtx_valid) mult_q <= (wtx_mult == '0) ? MULT_W'(1) : wtx_mult;
    else if (arm)       mult_q <= MULT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q       <= 1'b0;
      cnt_q         <= '0;
      lim_q         <= '0;
      block_timeout <= 1'b0;
    end else if (arm) begin
      armed_q       <= 1'b1;
      cnt_q         <= '0;
      lim_q         <= lim_next;
      block_timeout <= 1'b0;
    end else if (rx_start) begin
      armed_q       <= 1'b0;
      block_timeout <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q >= lim_q - BLK_W'(1)) begin
        block_timeout <= 1'b1;
        armed_q       <= 1'b0;
      end else begin
        cnt_q <= cnt_q + BLK_W'(1);
      end
    end
  end

  AST_BT_CLEARED_BY_ARM: assert property (@(posedge clk) disable iff (rst)
    arm |=> !block_timeout); // R6
  AST_BT_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(block_timeout) |-> $past(armed_q)); // R6
  AST_BT_STOPPED_BY_RX: assert property (@(posedge clk) disable iff (rst)
    (rx_start && !arm) |=> !block_timeout); // R7
  AST_MULT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    mult_q != '0); // R8
endmodule

// File: rtl/t1_wait_timer.sv
module t1_wait_timer #(
  parameter int IDX_W  = 4,
  parameter int DIV_W  = 16,
  parameter int MULT_W = 8,
  parameter int UNIT   = 960 * 372
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_etu_div,
  input  logic [IDX_W-1:0]  cfg_cwi,
  input  logic [IDX_W-1:0]  cfg_bwi,
  input  logic              rx_char_start,
  input  logic              tx_char_start,
  input  logic              tx_char_last,
  input  logic              wtx_valid,
  input  logic [MULT_W-1:0] wtx_mult,
  output logic              char_timeout,
  output logic              block_timeout,
  output logic              tx_allowed
);
  localparam int BLK_W = $clog2(UNIT + 1) + (1 << IDX_W) + MULT_W + 2;

  logic etu_tick;

  t1wt_etu_gen #(.DIV_W(DIV_W)) u_etu (
    .clk     (clk),
    .rst     (rst),
    .div     (cfg_etu_div),
    .restart (rx_char_start),
    .tick    (etu_tick)
  );

  t1wt_char_guard #(.IDX_W(IDX_W)) u_char (
    .clk          (clk),
    .rst          (rst),
    .tick         (etu_tick),
    .rx_start     (rx_char_start),
    .tx_start     (tx_char_start),
    .cwi          (cfg_cwi),
    .char_timeout (char_timeout),
    .tx_allowed   (tx_allowed)
  );

  t1wt_block_wait #(
    .IDX_W (IDX_W),
    .DIV_W (DIV_W),
    .MULT_W(MULT_W),
    .UNIT  (UNIT),
    .BLK_W (BLK_W)
  ) u_blk (
    .clk           (clk),
    .rst           (rst),
    .div           (cfg_etu_div),
    .bwi           (cfg_bwi),
    .arm           (tx_char_start && tx_char_last),
    .rx_start      (rx_char_start),
    .wtx_valid     (wtx_valid),
    .wtx_mult      (wtx_mult),
    .block_timeout (block_timeout)
  );
endmodule

// File: tb/t1_wait_timer_bench.sv
module t1_wait_timer_bench;
  localparam int UNIT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_etu_div = 16'd2;
  logic [3:0]  cfg_cwi = 4'd0;
  logic [3:0]  cfg_bwi = 4'd0;
  logic        rx_char_start = 1'b0;
  logic        tx_char_start = 1'b0;
  logic        tx_char_last = 1'b0;
  logic        wtx_valid = 1'b0;
  logic [7:0]  wtx_mult = 8'd0;
  logic        char_timeout, block_timeout, tx_allowed;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  t1_wait_timer #(.UNIT(UNIT)) u_t1_wait_timer (
    .clk(clk), .rst(rst), .cfg_etu_div(cfg_etu_div), .cfg_cwi(cfg_cwi),
    .cfg_bwi(cfg_bwi), .rx_char_start(rx_char_start),
    .tx_char_start(tx_char_start), .tx_char_last(tx_char_last),
    .wtx_valid(wtx_valid), .wtx_mult(wtx_mult),
    .char_timeout(char_timeout), .block_timeout(block_timeout),
    .tx_allowed(tx_allowed)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rx();
    @(negedge clk) rx_char_start = 1'b1;
    @(negedge clk) rx_char_start = 1'b0;
  endtask

  task automatic pulse_tx(input logic last);
    @(negedge clk) begin tx_char_start = 1'b1; tx_char_last = last; end
    @(negedge clk) begin tx_char_start = 1'b0; tx_char_last = 1'b0; end
  endtask

  task automatic pulse_wtx(input logic [7:0] m);
    @(negedge clk) begin wtx_valid = 1'b1; wtx_mult = m; end
    @(negedge clk) wtx_valid = 1'b0;
  endtask

  // arm a block wait and check the edge before and at expiry
  task automatic block_edge(input string tag, input int lim);
    pulse_tx(1'b1);
    chk({tag, " cleared on arm"}, block_timeout, 1'b0);
    wait_n(lim - 1);
    chk({tag, " before limit"}, block_timeout, 1'b0);
    wait_n(1);
    chk({tag, " at limit"}, block_timeout, 1'b1);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R5 reset state
    chk("R5 char_timeout", char_timeout, 1'b0);
    chk("R5 block_timeout", block_timeout, 1'b0);
    chk("R5 tx_allowed", tx_allowed, 1'b1);

    // R2 / R3: character wait sweep
    for (int d = 1; d <= 3; d++) begin
      for (int c = 0; c <= 3; c++) begin
        int lim;
        cfg_etu_div = 16'(d);
        cfg_cwi = 4'(c);
        lim = ((1 << c) + 11) * d;
        pulse_rx();
        chk("R3 cleared by rx", char_timeout, 1'b0);
        wait_n(lim - 1);
        chk("R2 before limit", char_timeout, 1'b0);
        wait_n(1);
        chk("R2 at limit", char_timeout, 1'b1);
      end
    end

    // R4 / R1: guard sweep, divisor 0 acts as 1
    for (int d = 0; d <= 3; d++) begin
      int de;
      de = (d == 0) ? 1 : d;
      cfg_etu_div = 16'(d);
      pulse_rx();
      chk("R4 closed after rx", tx_allowed, 1'b0);
      wait_n(22 * de - 1);
      chk("R1 R4 before guard", tx_allowed, 1'b0);
      wait_n(1);
      chk("R1 R4 at guard", tx_allowed, 1'b1);
    end

    // R1: a second rx restarts the etu phase and the guard
    cfg_etu_div = 16'd3;
    pulse_rx();
    wait_n(7);
    pulse_rx();
    wait_n(22 * 3 - 1);
    chk("R1 restart before guard", tx_allowed, 1'b0);
    wait_n(1);
    chk("R1 restart at guard", tx_allowed, 1'b1);

    // R10 / R9: tx without last ends char wait and does not arm
    cfg_etu_div = 16'd1;
    cfg_cwi = 4'd0;
    cfg_bwi = 4'd0;
    pulse_rx();
    wait_n(4);
    pulse_tx(1'b0);
    wait_n(30);
    chk("R10 char wait ended by tx", char_timeout, 1'b0);
    chk("R9 tx without last not armed", block_timeout, 1'b0);

    // R6: block wait sweep
    for (int d = 1; d <= 2; d++) begin
      for (int b = 0; b <= 3; b++) begin
        cfg_etu_div = 16'(d);
        cfg_bwi = 4'(b);
        block_edge("R6", (UNIT << b) + 11 * d);
      end
    end

    // R7: reply stops the block wait
    cfg_etu_div = 16'd1;
    cfg_bwi = 4'd1;
    pulse_tx(1'b1);
    wait_n(10);
    pulse_rx();
    wait_n(40);
    chk("R7 stopped by reply", block_timeout, 1'b0);

    // R8: extension applies once, zero acts as one
    cfg_etu_div = 16'd2;
    cfg_bwi = 4'd1;
    pulse_wtx(8'd3);
    block_edge("R8 extended", 3 * (UNIT << 1) + 22);
    block_edge("R8 back to one", (UNIT << 1) + 22);
    pulse_wtx(8'd0);
    block_edge("R8 zero as one", (UNIT << 1) + 22);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule